// File: doc/BRIEF.md
# Round-Robin Host-to-Controller Mailbox Writer

This block carries short commands from a host to an embedded controller through four mailbox slots that are used in turn. A command is an 8-bit element ID, a length of 1 to 5 bytes and up to five payload bytes. It arrives on a valid/ready handshake. Only one command is in flight at a time.

For the current slot, the block first checks that the controller has consumed the previous command in that slot. It reads a shared pending register and then the slot's own status byte. If the slot is still occupied, it waits a programmable number of cycles and checks again. After a bounded number of checks it gives up. Once the slot is free, it writes the command as byte writes over a byte-wide register-bus master port.

Short commands fit in the four-byte main mailbox. Longer ones set a flag bit in the first byte and put their first two payload bytes in a two-byte side register. The side register is written before the main mailbox. Each command ends with a one-cycle success or failure pulse.

Top module: `h2c_mailbox_writer`

## Requirements
- R1: `cmd_ready` is high exactly when no command is in flight. `busy` is its inverse. No bus request is made while `cmd_ready` is high. A command is accepted on a clock edge where both `cmd_valid` and `cmd_ready` are high.
- R2: A command with `cmd_len` of 0, 6 or 7 is rejected. `done_fail` pulses in the cycle after acceptance. No bus access is made, and the slot index does not change.
- R3: A slot s (0..3) counts as free only when bit s of the byte read from `PEND_ADDR` is 0 and the byte read from `STAT_BASE+s` is 0x00. The pending register is read first, then the status byte.
- R4: When the slot is not free, the check repeats after at least `RETRY_DLY` idle cycles, for at most `MAX_POLLS` checks in total. If the slot is still occupied after the last check, `done_fail` pulses, nothing is written and the slot index stays.
- R5: For lengths 1 to 3, main bytes 0..3 go to `BOX_BASE+4*s+0..3`, in that order. Byte 0 is the element ID with bit 7 cleared. Bytes 1..3 hold payload bytes 0..2. Payload bytes at or beyond the length are written as 0x00.
- R6: For lengths 4 and 5, payload bytes 0 and 1 are written to `EXT_BASE+2*s` and `EXT_BASE+2*s+1` first. Then main byte 0 is written as the ID with bit 7 set, and main bytes 1..3 carry payload bytes 2..4, with payload byte 4 written as 0x00 when the length is 4.
- R7: The slot index starts at 0 after reset. It advances by one after each successful command and wraps from 3 to 0.
- R8: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` hold their values into the next cycle. Read data is taken in the cycle in which `bus_ack` is high.
- R9: `done_ok` pulses for one cycle after the acknowledge of the last mailbox write. `done_ok` and `done_fail` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_id | input | 8 | Element ID |
| cmd_len | input | 3 | Payload length in bytes |
| cmd_payload | input | 40 | Payload, byte k at bits 8k+7:8k |
| busy | output | 1 | Command in flight |
| done_ok | output | 1 | Command written (pulse) |
| done_fail | output | 1 | Command rejected or timed out (pulse) |
| bus_req | output | 1 | Register-bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Byte address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Request completed |

## Verification
The assertions assume that the register bus raises `bus_ack` only while `bus_req` is high, and for a single cycle per request. They also assume that the command fields hold steady while `cmd_valid` waits. The bench's responder model keeps to this: it answers one cycle after a request and drops the acknowledge immediately. The driver task changes command inputs only on falling edges and holds them until acceptance. Slot occupancy is emulated by thresholds on the number of status reads per slot, so that pending-only, status-only and permanent occupancy can each be produced.

// File: rtl/h2c_mailbox_writer.sv
module h2c_mailbox_writer #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] PEND_ADDR = 'h0E0,
  parameter logic [ADDR_W-1:0] STAT_BASE = 'h0E4,
  parameter logic [ADDR_W-1:0] EXT_BASE  = 'h0E8,
  parameter logic [ADDR_W-1:0] BOX_BASE  = 'h0F0,
  parameter int MAX_POLLS = 100,
  parameter int RETRY_DLY = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_id,
  input  logic [2:0]        cmd_len,
  input  logic [39:0]       cmd_payload,
  output logic              busy,
  output logic              done_ok,
  output logic              done_fail,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic [7:0]        bus_rdata,
  input  logic              bus_ack
);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam int DW = $clog2(RETRY_DLY + 1);

  typedef enum logic [2:0] {S_IDLE, S_PEND, S_STAT, S_WAIT, S_WRITE} st_t;

  st_t         st;
  logic [1:0]  slot_q;
  logic [7:0]  id_q;
  logic        ext_q;
  logic [39:0] pay_q;
  logic [39:0] pay_m;
  logic [PW-1:0] polls_q;
  logic [DW-1:0] dly_q;
  logic [2:0]  wi_q;
  logic        pend_q;
  logic [7:0]  mb [4];

  wire len_ok = (cmd_len != 3'd0) && (cmd_len <= 3'd5);

  assign busy      = (st != S_IDLE);
  assign cmd_ready = !busy;
  assign bus_req   = (st == S_PEND) || (st == S_STAT) || (st == S_WRITE);
  assign bus_we    = (st == S_WRITE);

  always_comb begin
    for (int k = 0; k < 5; k++)
      pay_m[8*k +: 8] = (3'(k) < cmd_len) ? cmd_payload[8*k +: 8] : 8'h00;
  end

  assign mb[0] = {ext_q, id_q[6:0]};
  assign mb[1] = ext_q ? pay_q[23:16] : pay_q[7:0];
  assign mb[2] = ext_q ? pay_q[31:24] : pay_q[15:8];
  assign mb[3] = ext_q ? pay_q[39:32] : pay_q[23:16];

  always_comb begin
    bus_addr  = PEND_ADDR;
    bus_wdata = 8'h00;
    case (st)
      S_STAT: bus_addr = STAT_BASE + ADDR_W'(slot_q);
      S_WRITE: begin
        if (wi_q < 3'd2) begin
          bus_addr  = EXT_BASE + ADDR_W'({slot_q, 1'b0}) + ADDR_W'(wi_q);
          bus_wdata = wi_q[0] ? pay_q[15:8] : pay_q[7:0];
        end else begin
          bus_addr  = BOX_BASE + ADDR_W'({slot_q, 2'b00}) + ADDR_W'(wi_q - 3'd2);
          bus_wdata = mb[2'(wi_q - 3'd2)];
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; slot_q <= '0; id_q <= '0; ext_q <= 1'b0; pay_q <= '0;
      polls_q <= '0; dly_q <= '0; wi_q <= '0; pend_q <= 1'b0;
      done_ok <= 1'b0; done_fail <= 1'b0;
    end else begin
      done_ok   <= 1'b0;
      done_fail <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          if (!len_ok) done_fail <= 1'b1;
          else begin
            id_q <= cmd_id; ext_q <= (cmd_len >= 3'd4); pay_q <= pay_m;
            polls_q <= '0; st <= S_PEND;
          end
        end
        S_PEND: if (bus_ack) begin
          pend_q <= bus_rdata[slot_q];
          st <= S_STAT;
        end
        S_STAT: if (bus_ack) begin
          if (!pend_q && bus_rdata == 8'h00) begin
            wi_q <= ext_q ? 3'd0 : 3'd2;
            st <= S_WRITE;
          end else if (polls_q == PW'(MAX_POLLS - 1)) begin
            done_fail <= 1'b1;
            st <= S_IDLE;
          end else begin
            polls_q <= polls_q + 1'b1;
            dly_q <= '0;
            st <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (dly_q == DW'(RETRY_DLY - 1)) st <= S_PEND;
          else dly_q <= dly_q + 1'b1;
        end
        S_WRITE: if (bus_ack) begin
          if (wi_q == 3'd5) begin
            done_ok <= 1'b1;
            slot_q <= slot_q + 2'd1;
            st <= S_IDLE;
          end else wi_q <= wi_q + 3'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/h2c_mailbox_writer_chk.sv
module h2c_mailbox_writer_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_len,
  input logic              busy,
  input logic              done_ok,
  input logic              done_fail,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_ack
);
  a_r1_idle_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!busy && !bus_req));

  a_r2_len_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_len == 3'd0 || cmd_len > 3'd5)) |=> (done_fail && cmd_ready));

  a_r8_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

  a_r9_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_ok && done_fail));

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok || done_fail) |-> cmd_ready);
endmodule

bind h2c_mailbox_writer h2c_mailbox_writer_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_len(cmd_len), .busy(busy), .done_ok(done_ok), .done_fail(done_fail),
  .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_ack(bus_ack));

// File: tb/test_h2c_mailbox_writer.sv
module test_h2c_mailbox_writer;
  localparam int AW = 12;
  localparam logic [AW-1:0] PEND = 'h0E0, STAT = 'h0E4, EXT = 'h0E8, BOX = 'h0F0;
  localparam int POLLS = 100;
  localparam int DLY = 8;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_ready;
  logic [7:0] cmd_id = 0;
  logic [2:0] cmd_len = 0;
  logic [39:0] cmd_payload = 0;
  logic busy, done_ok, done_fail;
  logic bus_req, bus_we, bus_ack = 0;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata = 0;

  h2c_mailbox_writer #(.ADDR_W(AW), .PEND_ADDR(PEND), .STAT_BASE(STAT), .EXT_BASE(EXT),
    .BOX_BASE(BOX), .MAX_POLLS(POLLS), .RETRY_DLY(DLY)) i_h2c_mailbox_writer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_id(cmd_id), .cmd_len(cmd_len), .cmd_payload(cmd_payload), .busy(busy),
    .done_ok(done_ok), .done_fail(done_fail), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0;
  int sreads [4] = '{0, 0, 0, 0};
  int thr_p [4] = '{0, 0, 0, 0};
  int thr_s [4] = '{0, 0, 0, 0};
  logic [19:0] exp_w [$];
  bit exp_r [$];
  int res_cnt = 0, rd_cnt = 0, stat_cnt = 0;
  int last_stat = -1, min_gap = 1000000;
  int exp_slot = 0;
  logic hold_req = 0;
  logic [AW-1:0] hold_addr = 0;
  logic [7:0] hold_data = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) bus_ack <= 0;
    else begin
      bus_ack <= bus_req && !bus_ack;
      if (bus_req && !bus_ack && !bus_we) begin
        if (bus_addr == PEND) begin
          logic [7:0] v;
          v = 0;
          for (int s = 0; s < 4; s++) v[s] = sreads[s] < thr_p[s];
          bus_rdata <= v;
        end else begin
          int s;
          s = int'(bus_addr - STAT);
          bus_rdata <= (sreads[s] < thr_s[s]) ? 8'h5A : 8'h00;
          sreads[s] <= sreads[s] + 1;
        end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (hold_req) begin
      chk(bus_req && bus_addr == hold_addr && bus_wdata == hold_data, "R8 bus hold",
          {bus_req, bus_addr, bus_wdata}, {1'b1, hold_addr, hold_data});
    end
    hold_req = bus_req && !bus_ack;
    hold_addr = bus_addr;
    hold_data = bus_wdata;
    if (bus_req && bus_ack) begin
      if (bus_we) begin
        if (exp_w.size() == 0) chk(0, "R2/R4/R5/R6 unexpected write", {bus_addr, bus_wdata}, 0);
        else begin
          logic [19:0] e;
          e = exp_w.pop_front();
          chk({bus_addr, bus_wdata} == e, "R5/R6/R7 write", {bus_addr, bus_wdata}, e);
        end
      end else begin
        rd_cnt++;
        if (bus_addr != PEND) begin
          stat_cnt++;
          if (last_stat >= 0 && cyc - last_stat < min_gap) min_gap = cyc - last_stat;
          last_stat = cyc;
        end
      end
    end
    if (done_ok || done_fail) begin
      if (exp_r.size() == 0) chk(0, "R9 unexpected done", done_ok, 0);
      else begin
        bit e;
        e = exp_r.pop_front();
        chk(done_ok == e && done_fail == !e, "R2/R4/R9 result", done_ok, e);
        if (done_ok) chk(exp_w.size() == 0, "R9 done after last write", exp_w.size(), 0);
      end
      res_cnt++;
    end
  end

  task automatic send(input logic [7:0] id, input logic [2:0] len, input logic [39:0] pay,
                      input bit ok);
    int r;
    logic [7:0] p [5];
    r = res_cnt;
    stat_cnt = 0; last_stat = -1; min_gap = 1000000;
    for (int k = 0; k < 5; k++) p[k] = (k < int'(len)) ? pay[8*k +: 8] : 8'h00;
    if (ok) begin
      if (len <= 3'd3) begin
        exp_w.push_back({BOX + AW'(4*exp_slot), 1'b0, id[6:0]});
        for (int k = 0; k < 3; k++) exp_w.push_back({BOX + AW'(4*exp_slot + k + 1), p[k]});
      end else begin
        exp_w.push_back({EXT + AW'(2*exp_slot), p[0]});
        exp_w.push_back({EXT + AW'(2*exp_slot + 1), p[1]});
        exp_w.push_back({BOX + AW'(4*exp_slot), 1'b1, id[6:0]});
        for (int k = 0; k < 3; k++) exp_w.push_back({BOX + AW'(4*exp_slot + k + 1), p[k+2]});
      end
      exp_slot = (exp_slot + 1) % 4;
    end
    exp_r.push_back(ok);
    @(negedge clk);
    cmd_valid = 1; cmd_id = id; cmd_len = len; cmd_payload = pay;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
    if (len != 0 && len <= 5 && res_cnt == r)
      chk(busy && !cmd_ready, "R1 busy after accept", {busy, cmd_ready}, 2'b10);
    while (res_cnt == r) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_ready && !busy && !bus_req && !done_ok && !done_fail, "R1 reset state",
        {cmd_ready, busy, bus_req}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    send(8'hC1, 3'd1, 40'hEE_DD_CC_BB_11, 1);
    send(8'h12, 3'd2, 40'hEE_DD_CC_22_21, 1);
    send(8'h93, 3'd3, 40'hEE_DD_33_32_31, 1);
    send(8'h24, 3'd4, 40'hEE_44_43_42_41, 1);
    send(8'hA5, 3'd5, 40'h55_54_53_52_51, 1);
    begin
      int rc;
      rc = rd_cnt;
      send(8'h01, 3'd0, 40'h1, 0);
      send(8'h02, 3'd6, 40'h1, 0);
      send(8'h03, 3'd7, 40'h1, 0);
      chk(rd_cnt == rc, "R2 no bus access on bad length", rd_cnt, rc);
    end
    send(8'h06, 3'd1, 40'h66, 1);
    thr_p[2] = sreads[2] + 2;
    send(8'h07, 3'd2, 40'h7877, 1);
    chk(stat_cnt == 3, "R3 pending bit blocks", stat_cnt, 3);
    thr_s[3] = sreads[3] + 3;
    send(8'h08, 3'd3, 40'h8A8988, 1);
    chk(stat_cnt == 4, "R3 status byte blocks", stat_cnt, 4);
    chk(min_gap > DLY, "R4 retry spacing", min_gap, DLY + 1);
    thr_p[0] = sreads[0] + 1000;
    send(8'h09, 3'd4, 40'h9C9B9A99, 0);
    chk(stat_cnt == POLLS, "R4 poll limit", stat_cnt, POLLS);
    thr_p[0] = 0;
    send(8'h0A, 3'd5, 40'hAEADACABAA, 1);
    send(8'h0B, 3'd1, 40'hBB, 1);
    repeat (4) @(negedge clk);
    chk(exp_w.size() == 0 && exp_r.size() == 0, "R7 all items seen", exp_w.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule